// File: doc/BRIEF.md
# Misaligned Operand Bus Cycle Splitter

This block sits between a processor's operand requests and an external data port. The port is either 16 or 32 bits wide. Each request names a byte address, an operand size, a direction and write data, and says whether it is an instruction fetch. Data operands may start at any byte address. When an operand crosses the edge of a naturally aligned port-width window, the block issues several bus cycles in ascending address order. It moves each operand byte onto the byte lane that matches its address, and on reads it gathers the returned bytes into a right-justified result.

Instruction fetches must be word-aligned. An odd fetch address produces no bus cycle and raises an address-error pulse. An even fetch always takes one bus cycle. On a 32-bit port that cycle returns every byte from the fetch address to the end of its 4-byte window, which is two instruction words at a multiple of four. On a 16-bit port it returns one word.

Operand bytes are little-endian: byte j of the operand, counted from the least significant byte, lives at address addr+j. Byte lane i carries bus data bits [8i+7:8i] and holds the byte whose address modulo the port width equals i. A 16-bit port uses lanes 0 and 1 only. The input `port32` must not change while a request is in progress.

Top module: `opsplit`

## Requirements
- R1: A byte operand (size code 0) takes exactly one bus cycle at every address.
- R2: A word (size code 1, 2 bytes) or long word (size code 2, 4 bytes) takes one bus cycle for each port-width window it touches. Cycles are issued in ascending address order, and `bus_addr` carries the address of the first byte moved in that cycle. `bus_req` and the cycle's fields stay unchanged until `bus_ack`, and no cycle is issued beyond the last.
- R3: `bus_size` carries the number of operand bytes not yet moved at the start of the cycle, modulo 4, so that four bytes are coded as 0.
- R4: On writes, `bus_write` is 1. `bus_be` has one bit set for each lane moved in the cycle, and each enabled lane of `bus_wdata` holds the operand byte whose address matches that lane.
- R5: On data reads, only the enabled lanes of `bus_rdata` are used. The result on `rdata` is right-justified, with operand byte j in bits [8j+7:8j], and the bits above the operand are zero.
- R6: `done` is a one-cycle pulse in the cycle after the last acknowledged bus cycle, and `rdata` is valid from that pulse onward.
- R7: An instruction fetch at an odd address issues no bus cycle and no `done`. Instead, `addr_err` pulses for one cycle, in the cycle after the request is accepted.
- R8: An instruction fetch at an even address takes one read cycle. On a 32-bit port it moves 4 - (addr mod 4) bytes; on a 16-bit port it moves 2 bytes. Any write flag on a fetch is ignored.
- R9: `req_ready` is high exactly when no request is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On a 16-bit port, `bus_be[3:2]` stays zero.
- R10: An asynchronous low `rst_n` at once drops `bus_req`, `done` and `addr_err`, raises `req_ready` and clears `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port32 | input | 1 | 1 selects a 32-bit port, 0 a 16-bit port |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-justified write operand |
| req_ifetch | input | 1 | Request is an instruction fetch |
| bus_req | output | 1 | Bus cycle pending |
| bus_ack | input | 1 | Bus cycle completes this edge |
| bus_addr | output | 32 | Address of first byte in the cycle |
| bus_size | output | 2 | Bytes remaining, modulo 4 |
| bus_write | output | 1 | Cycle direction |
| bus_be | output | 4 | Per-lane byte enables |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the port |
| done | output | 1 | Operand finished |
| rdata | output | 32 | Assembled read result |
| addr_err | output | 1 | Odd instruction fetch pulse |

## Verification
Two events can share a cycle. The address-error pulse of a rejected odd fetch can coincide with the acceptance of the next request, and the `done` pulse of one operand can coincide with the edge where the next operand could be taken. The bench provokes the first case by holding `req_valid` high across an odd fetch while it changes the request fields to a misaligned read. It then requires a single error pulse, exactly one correct bus cycle for the second request, and a correct assembled result. The sweeps also start every operation directly after the previous `done`.

// File: rtl/opsplit.sv
module opsplit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port32,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  input  logic        req_ifetch,
  output logic        bus_req,
  input  logic        bus_ack,
  output logic [31:0] bus_addr,
  output logic [1:0]  bus_size,
  output logic        bus_write,
  output logic [3:0]  bus_be,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic [31:0] rdata,
  output logic        addr_err
);
  logic        busy, wr, done_q, err_q;
  logic [31:0] cur, wbuf, acc, rdata_q;
  logic [2:0]  rem;
  logic [1:0]  cons;

  logic [1:0]  off;
  logic [2:0]  room, k, dlen, flen;
  logic [3:0]  kmask;
  logic [31:0] bmask, lanes, merged;
  logic        accept;

  assign off    = port32 ? cur[1:0] : {1'b0, cur[0]};
  assign room   = (port32 ? 3'd4 : 3'd2) - {1'b0, off};
  assign k      = (rem < room) ? rem : room;
  assign kmask  = (4'd1 << k) - 4'd1;
  assign bmask  = {{8{kmask[3]}}, {8{kmask[2]}}, {8{kmask[1]}}, {8{kmask[0]}}};
  assign lanes  = (bus_rdata >> {off, 3'b000}) & bmask;
  assign merged = acc | (lanes << {cons, 3'b000});

  assign dlen   = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  assign flen   = port32 ? (3'd4 - {1'b0, req_addr[1], 1'b0}) : 3'd2;
  assign accept = req_valid && !busy;

  assign req_ready = !busy;
  assign bus_req   = busy;
  assign bus_addr  = cur;
  assign bus_size  = rem[1:0];
  assign bus_write = busy && wr;
  assign bus_be    = busy ? (kmask << off) : 4'd0;
  assign bus_wdata = (busy && wr) ? (wbuf << {off, 3'b000}) : 32'd0;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign addr_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr      <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cur     <= 32'd0;
      wbuf    <= 32'd0;
      acc     <= 32'd0;
      rdata_q <= 32'd0;
      rem     <= 3'd0;
      cons    <= 2'd0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (req_ifetch && req_addr[0]) begin
          err_q <= 1'b1;
        end else begin
          busy <= 1'b1;
          cur  <= req_addr;
          rem  <= req_ifetch ? flen : dlen;
          wr   <= req_write && !req_ifetch;
          cons <= 2'd0;
          wbuf <= req_wdata;
          acc  <= 32'd0;
        end
      end else if (busy && bus_ack) begin
        acc  <= merged;
        cur  <= cur + {29'd0, k};
        rem  <= rem - k;
        cons <= cons + k[1:0];
        wbuf <= wbuf >> {k, 3'b000};
        if (rem == k) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          if (!wr) rdata_q <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/opsplit_chk.sv
module opsplit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        port32,
  input logic        req_ready,
  input logic        bus_req,
  input logic        bus_ack,
  input logic [31:0] bus_addr,
  input logic [1:0]  bus_size,
  input logic [3:0]  bus_be,
  input logic        done,
  input logic        addr_err
);
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_size)));

  a_r2_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> (!bus_req || bus_addr > $past(bus_addr)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && bus_ack));

  a_r7_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!bus_req && !done));

  a_r9_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !port32) |-> (bus_be[3:2] == 2'b00));

  a_r4_be_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != 4'd0));
endmodule

bind opsplit opsplit_chk u_chk (.*);

// File: tb/test_opsplit.sv
module test_opsplit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, port32 = 0;
  logic        req_valid = 0, req_write = 0, req_ifetch = 0, bus_ack = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, bus_rdata = 0;
  logic [1:0]  req_size = 0;
  logic        req_ready, bus_req, bus_write, done, addr_err;
  logic [31:0] bus_addr, bus_wdata, rdata;
  logic [1:0]  bus_size;
  logic [3:0]  bus_be;

  int errors = 0, checks = 0;

  opsplit i_opsplit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mb(input logic [31:0] ad);
    return (ad[7:0] * 8'd29) ^ ad[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input bit p, input logic [31:0] ad, input logic [1:0] sz,
                       input bit w, input bit f, input logic [31:0] wd);
    @(negedge clk);
    port32 = p; req_addr = ad; req_size = sz; req_write = w; req_ifetch = f; req_wdata = wd;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic serve(input bit p, input logic [31:0] ad, input int n, input bit w,
                       input logic [31:0] wd, input string rtag);
    int W, o, k, r, cyc, cons, expw;
    logic [31:0] a, rd, expr;
    logic [3:0] ebe;
    W = p ? 4 : 2;
    a = ad; r = n; cyc = 0; cons = 0; expr = 0;
    for (int j = 0; j < n; j++) expr[8*j +: 8] = mb(ad + j);
    expw = int'((ad + n - 1) / W) - int'(ad / W) + 1;
    while (r > 0 && cyc < 8) begin
      o = int'(a % W);
      k = (r < W - o) ? r : W - o;
      ebe = 4'(((1 << k) - 1) << o);
      chk(bus_req == 1, "R2 bus_req", 32'(bus_req), 1);
      chk(bus_addr == a, "R2 bus_addr", bus_addr, a);
      chk(bus_size == 2'(r % 4), "R3 bus_size", 32'(bus_size), 32'(r % 4));
      chk(bus_be == ebe, "R4 bus_be", 32'(bus_be), 32'(ebe));
      chk(bus_write == w, "R4 bus_write", 32'(bus_write), 32'(w));
      chk(req_ready == 0, "R9 ready while busy", 32'(req_ready), 0);
      if (w) for (int j = 0; j < k; j++)
        chk(bus_wdata[8*(o+j) +: 8] == wd[8*(cons+j) +: 8], "R4 lane data",
            32'(bus_wdata[8*(o+j) +: 8]), 32'(wd[8*(cons+j) +: 8]));
      if (((cyc + int'(a[1:0])) % 2) == 1) begin
        @(negedge clk);
        chk(bus_req == 1 && bus_addr == a && done == 0, "R2 hold during stall", bus_addr, a);
      end
      for (int i = 0; i < 4; i++)
        rd[8*i +: 8] = (p || i < 2) ? mb(a - o + i) : 8'hEE;
      bus_rdata = rd; bus_ack = 1;
      @(negedge clk);
      bus_ack = 0; bus_rdata = 32'hDEAD_BEEF;
      a = a + k; r = r - k; cons = cons + k; cyc++;
      if (r > 0) chk(done == 0, "R6 early done", 32'(done), 0);
    end
    chk(cyc == expw, (n == 1) ? "R1 byte cycles" : "R2 cycle count", cyc, expw);
    chk(bus_req == 0, "R2 no extra cycle", 32'(bus_req), 0);
    chk(done == 1, "R6 done pulse", 32'(done), 1);
    if (!w) chk(rdata == expr, rtag, rdata, expr);
    @(negedge clk);
    chk(done == 0, "R6 done width", 32'(done), 0);
    if (!w) chk(rdata == expr, "R6 rdata held", rdata, expr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] base, wd;
    int n;
    #1;
    chk(bus_req == 0 && done == 0 && addr_err == 0, "R10 reset outputs", 32'({bus_req, done, addr_err}), 0);
    chk(req_ready == 1 && rdata == 0, "R10 reset ready/rdata", rdata, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    base = 32'h1234_5600;

    for (int p = 0; p < 2; p++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 8; off++)
          for (int w = 0; w < 2; w++) begin
            n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            wd = 32'h0;
            for (int j = 0; j < n; j++) wd[8*j +: 8] = 8'(8'h11 * (j + 1) + off);
            start(p[0], base + 32'(off), 2'(sz), w[0], 1'b0, wd);
            serve(p[0], base + 32'(off), n, w[0], wd, "R5 read assembly");
          end

    for (int p = 0; p < 2; p++)
      for (int off = 0; off < 8; off++) begin
        if (off % 2 == 1) begin
          start(p[0], base + 32'(off), 2'd2, 1'b0, 1'b1, 0);
          chk(addr_err == 1, "R7 error pulse", 32'(addr_err), 1);
          chk(bus_req == 0 && done == 0, "R7 no bus cycle", 32'({bus_req, done}), 0);
          @(negedge clk);
          chk(addr_err == 0 && bus_req == 0 && done == 0, "R7 pulse width", 32'({addr_err, bus_req, done}), 0);
        end else begin
          n = p ? 4 - (off % 4) : 2;
          start(p[0], base + 32'(off), 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF);
          serve(p[0], base + 32'(off), n, 1'b0, 0, "R8 fetch result");
        end
      end

    // addr_err of an odd fetch in the same cycle as the next acceptance
    @(negedge clk);
    port32 = 1; req_addr = base + 32'd3; req_ifetch = 1; req_write = 0; req_size = 2'd0;
    req_valid = 1;
    @(negedge clk);
    chk(addr_err == 1 && req_ready == 1, "R7 error with ready", 32'({addr_err, req_ready}), 3);
    req_addr = base + 32'd5; req_ifetch = 0; req_size = 2'd1;
    @(negedge clk);
    req_valid = 0;
    chk(addr_err == 0, "R7 single pulse", 32'(addr_err), 0);
    serve(1'b1, base + 32'd5, 2, 1'b0, 0, "R9 back-to-back accept");

    // asynchronous reset in the middle of a split read
    start(1'b0, base + 32'd3, 2'd2, 1'b0, 1'b0, 0);
    bus_rdata = 32'hFFFF_FFFF; bus_ack = 1;
    @(negedge clk);
    bus_ack = 0;
    chk(bus_req == 1, "R2 mid-op busy", 32'(bus_req), 1);
    #2 rst_n = 0;
    #1;
    chk(bus_req == 0 && req_ready == 1, "R10 async drop", 32'({bus_req, req_ready}), 1);
    chk(rdata == 0, "R10 rdata cleared", rdata, 0);
    @(negedge clk);
    rst_n = 1;
    start(1'b0, base + 32'd1, 2'd1, 1'b0, 1'b0, 0);
    serve(1'b0, base + 32'd1, 2, 1'b0, 0, "R10 recovery read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule